// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel sample pairs. It is always a clock slave. The bit clock runs the block, and the word select and serial data lines are sampled on each rising bit-clock edge. The block never drives any of these lines.

A two-bit control input picks the framing convention: I2S, MSB-justified or LSB-justified. A second two-bit input picks the word length. The whole path works on 24-bit words. Each finished left/right pair appears on two 24-bit outputs, together with a one-cycle valid strobe in the bit-clock domain. Clock recovery and any transfer into another clock domain are handled outside the block.

The format and word-length inputs are expected to stay fixed while a stream runs. Reset is synchronous and active low. After reset the block waits for a word-select transition before it trusts the framing.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held low at a rising edge, the block clears the left sample, the right sample and the valid strobe to zero on that edge.
- R2: With format code 0 (I2S), the MSB of a word is sampled on the second rising edge after word select changes. Word select low carries the left word and high carries the right word.
- R3: With format code 1 (MSB-justified), the MSB is sampled on the first rising edge on which the new word-select level is seen, using the same channel polarity as R2.
- R4: With format code 2 (LSB-justified), the bit sampled on the last edge before the word-select change is the LSB. The final N bits of the half-frame form the word, which is sign-extended from bit N-1 up to 24 bits.
- R5: In I2S and MSB-justified modes, word-length code 0, 1, 2 or 3 selects 16, 18, 20 or 24 bits. Bits that arrive after the first N bits of a half-frame have no effect on the output.
- R6: In I2S and MSB-justified modes, a word shorter than 24 bits is placed in the top N bits of the output, and the low 24-N bits are zero.
- R7: In LSB-justified mode, word-length codes 0, 1 and 2 select 16, 18 and 20 bits. Code 3 is treated as 20 bits, because 24-bit words are not accepted in this mode.
- R8: The valid strobe is high for exactly one cycle. It rises after the edge that ends the right half-frame: in MSB- and LSB-justified modes this is the edge where the word-select fall is first sampled, and in I2S mode it is one edge later. The left and right sample outputs change only together with the strobe.
- R9: Samples taken before the first word-select transition after reset are dropped. A pair is reported only when a left word is followed by a right word.
- R10: Format code 3 behaves exactly like I2S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External bit clock; data and word select are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ws_i | input | 1 | Word select: low for left, high for right |
| sd_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 2 | Framing: 0 I2S, 1 MSB-justified, 2 LSB-justified, 3 as I2S |
| wlen_i | input | 2 | Word length code (see R5, R7) |
| left_o | output | 24 | Last completed left sample |
| right_o | output | 24 | Last completed right sample |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
On the edge that ends a half-frame, the block does two jobs at once: it closes the word just finished (and may raise the strobe) and it takes in the first bit of the next word. In I2S mode, the LSB of the old word also arrives on the edge where word select changes. The driver sends frames back to back with no idle bits, including half-frames exactly 24 bits long. Distinct left and right values are used so that a bit lost or shifted across the boundary changes the result. The scoreboard pairs each strobe with the words the driver queued, which judges the placement at both ends of every word.

// File: rtl/sarx_pkg.sv
// Package: shared constants, format codes and word-length decode for the
// serial audio receiver. Assumes the format inputs stay steady during a stream.
package sarx_pkg;

    localparam int SAMPLE_W  = 24;   // parallel sample width
    localparam int LSB_MAX_W = 20;   // longest word accepted in LSB-justified mode
    localparam int IDX_W     = 6;    // bit-position counter width (saturating)

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_MSBJ = 2'b01,
        FMT_LSBJ = 2'b10,
        FMT_ALT  = 2'b11
    } fmt_e;

    // Number of payload bits for a word-length code under a given format.
    function automatic int unsigned word_bits(fmt_e f, logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return (f == FMT_LSBJ) ? LSB_MAX_W : SAMPLE_W;
        endcase
    endfunction

endpackage

// File: rtl/sarx_frame_tracker.sv
// Frame tracker: finds half-frame boundaries and the position of each bit
// within its half-frame. For I2S the word select is taken one edge late, so
// the I2S framing becomes MSB-justified framing on a delayed select.
// Assumes: runs on the bit clock; reset is synchronous, active low.
module sarx_frame_tracker #(
    parameter int IDX_W = sarx_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ws_i,
    input  logic             i2s_dly_i,
    output logic             bnd_o,
    output logic             done_ch_o,
    output logic             synced_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             ws_q, ws_qq, synced_q;
    logic [IDX_W-1:0] pos_q;
    logic             fws, fws_prev;

    // Pick the framing select and its previous value for the current format.
    always_comb begin
        fws       = i2s_dly_i ? ws_q  : ws_i;
        fws_prev  = i2s_dly_i ? ws_qq : ws_q;
        bnd_o     = fws ^ fws_prev;
        done_ch_o = fws_prev;
        synced_o  = synced_q;
        idx_o     = bnd_o ? '0 : pos_q;
    end

    // Keep the select history, the sync flag and the next bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q     <= 1'b0;
            ws_qq    <= 1'b0;
            synced_q <= 1'b0;
            pos_q    <= '0;
        end else begin
            ws_q  <= ws_i;
            ws_qq <= ws_q;
            if (bnd_o)
                synced_q <= 1'b1;
            if (bnd_o)
                pos_q <= IDX_W'(1);
            else if (pos_q != IDX_MAX)
                pos_q <= pos_q + 1'b1;
        end
    end

    // Once the framing has locked it stays locked until reset.
    assert_sync_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        synced_o |=> synced_o);

    // A position past the last one stays parked until the next boundary.
    assert_pos_parks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o == IDX_MAX && !bnd_o) |=> (bnd_o || idx_o == IDX_MAX));

endmodule

// File: rtl/sarx_word_assembler.sv
// Word assembler: builds the word of the current half-frame. There are two
// stores. A placement register writes the first N bits MSB-first, for I2S and
// MSB-justified modes. A short shift register keeps the trailing bits, for
// LSB-justified mode. word_o is the finished word of the half-frame that ends
// at a boundary edge.
// Assumes: nb_i is between 16 and SAMPLE_W, and at most LSB_MAX_W in LSB mode.
module sarx_word_assembler #(
    parameter int SAMPLE_W  = sarx_pkg::SAMPLE_W,
    parameter int LSB_MAX_W = sarx_pkg::LSB_MAX_W,
    parameter int IDX_W     = sarx_pkg::IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd_i,
    input  logic                bnd_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [IDX_W-1:0]    nb_i,
    input  logic                lsb_mode_i,
    output logic [SAMPLE_W-1:0] word_o
);
    logic [SAMPLE_W-1:0]  acc_q, acc_n;
    logic [LSB_MAX_W-1:0] sr_q;
    logic [SAMPLE_W-1:0]  lsb_word;
    logic                 sign;

    // Write the incoming bit into its MSB-first slot; start clean at a boundary.
    always_comb begin
        acc_n = bnd_i ? '0 : acc_q;
        for (int k = 0; k < SAMPLE_W; k++) begin
            if (idx_i == IDX_W'(k) && IDX_W'(k) < nb_i)
                acc_n[SAMPLE_W-1-k] = sd_i;
        end
    end

    // Sign-extend the trailing N bits for LSB-justified words.
    always_comb begin
        sign = 1'b0;
        for (int j = 0; j < LSB_MAX_W; j++) begin
            if (IDX_W'(j) == nb_i - 1'b1)
                sign = sr_q[j];
        end
        for (int k = 0; k < LSB_MAX_W; k++)
            lsb_word[k] = (IDX_W'(k) < nb_i) ? sr_q[k] : sign;
        for (int k = LSB_MAX_W; k < SAMPLE_W; k++)
            lsb_word[k] = sign;
    end

    // Pick the finished word for the active format.
    always_comb begin
        word_o = lsb_mode_i ? lsb_word : acc_q;
    end

    // Update both stores on every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sr_q  <= '0;
        end else begin
            acc_q <= acc_n;
            sr_q  <= {sr_q[LSB_MAX_W-2:0], sd_i};
        end
    end

    // Bits beyond the word length leave the placement register untouched.
    assert_tail_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bnd_i && idx_i >= nb_i) |=> $stable(acc_q));

endmodule

// File: rtl/sarx_pair_output.sv
// Pair output: holds a finished left word until its right partner arrives.
// The pair is then published together with a one-cycle strobe.
// Assumes: boundary and channel info come from the frame tracker on the same edge.
module sarx_pair_output #(
    parameter int SAMPLE_W = sarx_pkg::SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bnd_i,
    input  logic                synced_i,
    input  logic                done_ch_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic [SAMPLE_W-1:0] left_hold;
    logic                left_seen;

    // Pair finished words and publish each complete left/right pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_seen <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (bnd_i && synced_i) begin
                if (!done_ch_i) begin
                    left_hold <= word_i;
                    left_seen <= 1'b1;
                end else begin
                    if (left_seen) begin
                        left_o  <= left_hold;
                        right_o <= word_i;
                        valid_o <= 1'b1;
                    end
                    left_seen <= 1'b0;
                end
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && left_o == '0 && right_o == '0));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    assert_left_before_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(left_seen));

endmodule

// File: rtl/serial_audio_rx.sv
// Top: slave-mode serial audio receiver for I2S, MSB-justified and
// LSB-justified framing. It decodes the format controls and connects the
// frame tracker, the word assembler and the pair output.
// Assumes: fmt_i and wlen_i stay fixed during a stream; reset is synchronous, active low.
module serial_audio_rx #(
    parameter int SAMPLE_W  = sarx_pkg::SAMPLE_W,
    parameter int LSB_MAX_W = sarx_pkg::LSB_MAX_W,
    parameter int IDX_W     = sarx_pkg::IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ws_i,
    input  logic                sd_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wlen_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    import sarx_pkg::*;

    fmt_e                fmt;
    logic                i2s_dly, lsb_mode;
    logic [IDX_W-1:0]    nb;
    logic                bnd, done_ch, synced;
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] word;

    // Decode the format and word-length controls.
    always_comb begin
        fmt      = fmt_e'(fmt_i);
        lsb_mode = (fmt == FMT_LSBJ);
        i2s_dly  = (fmt == FMT_I2S) || (fmt == FMT_ALT);
        nb       = IDX_W'(word_bits(fmt, wlen_i));
    end

    sarx_frame_tracker #(.IDX_W(IDX_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ws_i      (ws_i),
        .i2s_dly_i (i2s_dly),
        .bnd_o     (bnd),
        .done_ch_o (done_ch),
        .synced_o  (synced),
        .idx_o     (idx)
    );

    sarx_word_assembler #(
        .SAMPLE_W (SAMPLE_W),
        .LSB_MAX_W(LSB_MAX_W),
        .IDX_W    (IDX_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_i      (sd_i),
        .bnd_i     (bnd),
        .idx_i     (idx),
        .nb_i      (nb),
        .lsb_mode_i(lsb_mode),
        .word_o    (word)
    );

    sarx_pair_output #(.SAMPLE_W(SAMPLE_W)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .bnd_i    (bnd),
        .synced_i (synced),
        .done_ch_i(done_ch),
        .word_i   (word),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

    // LSB-justified words (20 bits at most) carry copies of the sign above bit 19.
    assert_lsb_signext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_i == 2'b10) |->
        ((right_o[SAMPLE_W-1:LSB_MAX_W-1] == '0 || right_o[SAMPLE_W-1:LSB_MAX_W-1] == '1) &&
         (left_o[SAMPLE_W-1:LSB_MAX_W-1]  == '0 || left_o[SAMPLE_W-1:LSB_MAX_W-1]  == '1)));

    // A 16-bit word in a left-aligned mode leaves the low byte clear.
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_i != 2'b10 && wlen_i == 2'b00) |->
        (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));

endmodule

// File: tb/serial_audio_rx_tb.sv
// Scoreboard bench: the frame driver queues expected pairs, and a monitor
// pops and compares them on each strobe.
module serial_audio_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_i = 1'b0;
    logic        sd_i = 1'b0;
    logic [1:0]  fmt_i = 2'b01;
    logic [1:0]  wlen_i = 2'b11;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [47:0] q_data[$];
    string       q_tag[$];
    logic        prev_valid = 1'b0;
    logic        timed_out = 1'b0;

    always #5 clk = ~clk;

    serial_audio_rx u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .ws_i   (ws_i),
        .sd_i   (sd_i),
        .fmt_i  (fmt_i),
        .wlen_i (wlen_i),
        .left_o (left_o),
        .right_o(right_o),
        .valid_o(valid_o)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: check the strobe width and compare each pair with the queue.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            n_tests++;
            if (prev_valid) begin
                n_fail++;
                $display("FAIL R8 strobe width actual=2+ expected=1");
            end
            if (q_data.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R9 unexpected pair actual=%h/%h expected=none", left_o, right_o);
            end else begin
                logic [47:0] e;
                string t;
                e = q_data.pop_front();
                t = q_tag.pop_front();
                check({t, " left"},  left_o,  e[47:24]);
                check({t, " right"}, right_o, e[23:0]);
            end
        end
        prev_valid = rst_n && valid_o;
    end

    task automatic drive_bit(input logic w, input logic d);
        @(negedge clk);
        ws_i = w;
        sd_i = d;
    endtask

    function automatic logic [23:0] expect_word(input int fmt, input int n, input logic [23:0] raw);
        logic [23:0] r;
        r = '0;
        if (fmt == 2) begin
            for (int i = 0; i < 24; i++) r[i] = (i < n) ? raw[i] : raw[n-1];
        end else begin
            for (int i = 0; i < n; i++) r[23-i] = raw[n-1-i];
        end
        return r;
    endfunction

    // Reset and check the cleared outputs (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ws_i = 1'b0; sd_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 left", left_o, 24'h0);
        check("R1 right", right_o, 24'h0);
        check("R1 valid", {23'h0, valid_o}, 24'h0);
        rst_n = 1'b1;
    endtask

    // Start a stream: a right-only preamble that must be dropped (R9).
    task automatic start_stream(input int fmt, input int wl);
        fmt_i  = 2'(fmt);
        wlen_i = 2'(wl);
        do_reset();
        repeat (4) drive_bit(1'b1, 1'b1);
        if (fmt == 0 || fmt == 3) drive_bit(1'b0, 1'b0);
    endtask

    // Drive one frame of H bits per half; padding bits are driven as ones.
    task automatic send_frame(input int fmt, input int n, input int h,
                              input logic [23:0] lraw, input logic [23:0] rraw, input string tag);
        logic d, w, ch_next;
        logic [23:0] word;
        q_data.push_back({expect_word(fmt, n, lraw), expect_word(fmt, n, rraw)});
        q_tag.push_back(tag);
        for (int j = 0; j < 2*h; j++) begin
            int i;
            i    = (j < h) ? j : j - h;
            word = (j < h) ? lraw : rraw;
            if (fmt == 2) d = (i >= h - n) ? word[h-1-i] : 1'b1;
            else          d = (i < n) ? word[n-1-i] : 1'b1;
            ch_next = ((j + 1) % (2*h)) >= h;
            w = (fmt == 0 || fmt == 3) ? ch_next : (j >= h);
            drive_bit(w, d);
        end
    endtask

    // End a stream: let the last pair out and confirm none is missing (R8).
    task automatic end_stream(input string tag);
        repeat (4) drive_bit(1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check({tag, " R8 pairs left in queue"}, 24'(q_data.size()), 24'h0);
        q_data.delete();
        q_tag.delete();
    endtask

    initial begin
        fork
            begin
                // R3: MSB-justified, 24-bit, padded and exact half-frames
                start_stream(1, 3);
                send_frame(1, 24, 32, 24'h123456, 24'hABCDEF, "R3 msbj 24/32");
                send_frame(1, 24, 32, 24'h800001, 24'h7FFFFF, "R3 msbj 24/32 b");
                send_frame(1, 24, 24, 24'hA5A5A5, 24'h5A5A5A, "R3 msbj 24/24");
                send_frame(1, 24, 24, 24'hFFFFFF, 24'h000001, "R3 msbj 24/24 b");
                end_stream("R3");
                // R5/R6: shorter words, tail bits driven high must be ignored
                start_stream(1, 0);
                send_frame(1, 16, 32, 24'h00BEEF, 24'h001234, "R6 msbj 16");
                end_stream("R6");
                start_stream(1, 1);
                send_frame(1, 18, 20, 24'h02AAAA, 24'h015555, "R5 msbj 18");
                end_stream("R5");
                // R2: I2S framing, one-bit delay
                start_stream(0, 3);
                send_frame(0, 24, 32, 24'hC0FFEE, 24'h0BADF0, "R2 i2s 24/32");
                send_frame(0, 24, 24, 24'hF0F0F1, 24'h0F0F0E, "R2 i2s 24/24");
                end_stream("R2");
                start_stream(0, 2);
                send_frame(0, 20, 24, 24'h0ABCDE, 24'h054321, "R2 i2s 20");
                end_stream("R2b");
                // R10: code 3 acts as I2S
                start_stream(3, 3);
                send_frame(3, 24, 32, 24'h314159, 24'h271828, "R10 alt");
                end_stream("R10");
                // R4: LSB-justified, sign extension
                start_stream(2, 0);
                send_frame(2, 16, 32, 24'h008123, 24'h001234, "R4 lsbj 16");
                end_stream("R4");
                start_stream(2, 1);
                send_frame(2, 18, 24, 24'h020001, 24'h01FFFF, "R4 lsbj 18");
                end_stream("R4b");
                start_stream(2, 2);
                send_frame(2, 20, 32, 24'h0FFFFF, 24'h07FFFF, "R4 lsbj 20");
                end_stream("R4c");
                // R7: code 3 in LSB mode means 20 bits
                start_stream(2, 3);
                send_frame(2, 20, 20, 24'h080000, 24'h000001, "R7 lsbj code3");
                send_frame(2, 20, 24, 24'hF12345, 24'h0FEDCB, "R7 lsbj code3 b");
                end_stream("R7");
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule